// File: doc/BRIEF.md
# Debug Vector Catch Unit

This block lets a debugger trap execution at exception vector addresses. A debugger programs a control register over a small register bus. Each bit of that register arms one exception vector. The block compares the address of every committed instruction against the armed vector addresses. When one of them matches, it produces a single-cycle event. The comparison is made on the commit stream, not on exception entry, so a plain branch that lands on a vector also triggers a catch.

The vector table can sit at a low base (0x00000000) or a high base (0xFFFF0000). When an external interrupt controller supplies handler addresses, the IRQ slot instead compares against the last handler address it supplied, whichever base is selected. The debug mode input decides where the event goes: to a halt request, to a debug exception, or nowhere when monitor-style debugging is active. The block produces no event in monitor mode, which stops a debugger from locking the core into an unrecoverable state.

Top module: `dbg_vcatch_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all enable bits clear. `halt_req` and `dbg_exc` are low after that edge, and a read of the control register returns 0.
- R2: A write with `reg_wr_en` high and `reg_addr[7:2]` equal to the register offset (default 0x1C) updates the register. `reg_rdata` is registered: it shows the register one cycle after the address is presented. Writes to any other address are ignored, and reads of any other address return 0.
- R3: Bit 5 and bits 31:8 are reserved. They always read 0, writes to them are ignored, and setting bit 5 never arms a catch (for example, 0xFFFFFFFF reads back as 0x000000DF).
- R4: With the low base, enable bits 0, 1, 2, 3, 4, 6 and 7 arm vectors at 0x00, 0x04, 0x08, 0x0C, 0x10, 0x18 and 0x1C.
- R5: With `high_vec_sel` = 1, the same bits arm the same offsets above base 0xFFFF0000. Low-base addresses then no longer match.
- R6: With `ext_irq_en` = 1, enable bit 6 matches `ext_irq_addr` instead of offset 0x18, under either base.
- R7: A catch needs `commit_valid` = 1, a full 32-bit equality between `commit_addr` and an armed vector address, and the matching enable bit set. Any committed address counts, not only exception entry.
- R8: When `dbg_mode` is 2'b10 or 2'b11 (monitor mode), no catch event is produced, whatever the enable bits are.
- R9: With `dbg_mode` = 2'b00, a catch drives `halt_req`. With `dbg_mode` = 2'b01, it drives `dbg_exc`. The two outputs are never high together.
- R10: The event output goes high for exactly the cycle that follows the clock edge that sampled the matching commit. Back-to-back matching commits give one high cycle each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address (word aligned) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| high_vec_sel | input | 1 | Selects the 0xFFFF0000 vector base |
| ext_irq_en | input | 1 | IRQ slot uses the external handler address |
| ext_irq_addr | input | 32 | Last IRQ handler address from the interrupt controller |
| dbg_mode | input | 2 | 00 halt, 01 debug exception, 1x monitor |
| commit_valid | input | 1 | Commit strobe |
| commit_addr | input | 32 | Address of the committed instruction |
| halt_req | output | 1 | One-cycle halt request on a catch |
| dbg_exc | output | 1 | One-cycle debug exception on a catch |

## Verification
Every result of this block is due one clock edge after its stimulus. A write is visible to the matcher from the next commit onward. Read data appears after the edge that samples the address, and a catch shows on `halt_req` or `dbg_exc` after the edge that samples the commit. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge, so each check looks at exactly the cycle where its result is due. It then samples one cycle later to confirm that the event has dropped again.

// File: rtl/vcatch_pkg.sv
package vcatch_pkg;
  localparam int          NUM_VEC   = 8;
  localparam int          IRQ_IDX   = 6;
  localparam logic [7:0]  IMPL_MASK = 8'hDF;
  localparam logic [31:0] HIGH_BASE = 32'hFFFF_0000;

  typedef enum logic [1:0] {
    MODE_HALT = 2'b00,
    MODE_EXC  = 2'b01,
    MODE_MON  = 2'b10,
    MODE_MON2 = 2'b11
  } dbg_mode_e;
endpackage

// File: rtl/vcatch_ctrl_reg.sv
module vcatch_ctrl_reg
  import vcatch_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 8,
  parameter logic [7:0]  REG_OFFSET = 8'h1C
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [NUM_VEC-1:0] enables
);
  localparam int PAD_W = DATA_W - NUM_VEC;

  logic               sel;
  logic [NUM_VEC-1:0] en_q;

  assign sel = (addr[ADDR_W-1:2] == REG_OFFSET[ADDR_W-1:2]);

  // Only implemented bits are stored; reserved bits never hold state.
  always_ff @(posedge clk) begin
    if (rst)
      en_q <= '0;
    else if (wr_en && sel)
      en_q <= wdata[NUM_VEC-1:0] & IMPL_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else
      rdata <= sel ? {{PAD_W{1'b0}}, en_q} : '0;
  end

  assign enables = en_q;

  // R1: reset clears every enable
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> (en_q == '0));
  // R3: reserved read bits stay zero
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (rdata[DATA_W-1:NUM_VEC] == '0) && !rdata[5]);
  // R2: a register write to another address leaves the enables untouched
  a_r2_other_addr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sel) |=> $stable(en_q));
endmodule

// File: rtl/vcatch_addr_match.sv
module vcatch_addr_match
  import vcatch_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               high_sel,
  input  logic               ext_irq_en,
  input  logic [DATA_W-1:0]  ext_irq_addr,
  input  logic               commit_valid,
  input  logic [DATA_W-1:0]  commit_addr,
  input  logic [NUM_VEC-1:0] enables,
  output logic               hit
);
  logic [DATA_W-1:0]  base;
  logic [NUM_VEC-1:0] slot_hit;

  assign base = high_sel ? DATA_W'(HIGH_BASE) : '0;

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_slot
    logic [DATA_W-1:0] vec_addr;
    if (i == IRQ_IDX) begin : g_irq
      assign vec_addr = ext_irq_en ? ext_irq_addr : base + DATA_W'(i * 4);
    end else begin : g_fixed
      assign vec_addr = base + DATA_W'(i * 4);
    end
    assign slot_hit[i] = IMPL_MASK[i] && enables[i] && (commit_addr == vec_addr);
  end

  assign hit = commit_valid && (|slot_hit);

  // R7: no catch without a committed instruction
  a_r7_needs_commit: assert property (@(posedge clk) disable iff (rst)
    !commit_valid |-> !hit);
  // R7: no catch while every enable is clear
  a_r7_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (enables == '0) |-> !hit);
endmodule

// File: rtl/vcatch_event_route.sv
module vcatch_event_route
  import vcatch_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hit,
  input  logic [1:0] mode,
  output logic       halt_req,
  output logic       dbg_exc
);
  dbg_mode_e mode_e;
  assign mode_e = dbg_mode_e'(mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_req <= 1'b0;
      dbg_exc  <= 1'b0;
    end else begin
      halt_req <= hit && (mode_e == MODE_HALT);
      dbg_exc  <= hit && (mode_e == MODE_EXC);
    end
  end

  // R8: monitor mode yields no event
  a_r8_monitor_silent: assert property (@(posedge clk) disable iff (rst)
    mode[1] |=> (!halt_req && !dbg_exc));
  // R9: at most one route is active
  a_r9_one_route: assert property (@(posedge clk) disable iff (rst)
    !(halt_req && dbg_exc));
  // R10: no hit, no event in the next cycle
  a_r10_pulse_drop: assert property (@(posedge clk) disable iff (rst)
    !hit |=> (!halt_req && !dbg_exc));
endmodule

// File: rtl/dbg_vcatch_unit.sv
module dbg_vcatch_unit
  import vcatch_pkg::*;
#(
  parameter int         DATA_W     = 32,
  parameter int         ADDR_W     = 8,
  parameter logic [7:0] REG_OFFSET = 8'h1C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              high_vec_sel,
  input  logic              ext_irq_en,
  input  logic [DATA_W-1:0] ext_irq_addr,
  input  logic [1:0]        dbg_mode,
  input  logic              commit_valid,
  input  logic [DATA_W-1:0] commit_addr,
  output logic              halt_req,
  output logic              dbg_exc
);
  logic [NUM_VEC-1:0] enables;
  logic               hit;

  vcatch_ctrl_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_reg (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .enables(enables)
  );

  vcatch_addr_match #(.DATA_W(DATA_W)) u_match (
    .clk(clk), .rst(rst), .high_sel(high_vec_sel), .ext_irq_en(ext_irq_en),
    .ext_irq_addr(ext_irq_addr), .commit_valid(commit_valid),
    .commit_addr(commit_addr), .enables(enables), .hit(hit)
  );

  vcatch_event_route u_route (
    .clk(clk), .rst(rst), .hit(hit), .mode(dbg_mode),
    .halt_req(halt_req), .dbg_exc(dbg_exc)
  );
endmodule

// File: tb/test_dbg_vcatch_unit.sv
module test_dbg_vcatch_unit;
  localparam logic [7:0] OFS = 8'h1C;
  localparam int ROW_W = 102;
  localparam int NROWS = 22;

  // Row: {ctrl[32], mode[2], high, ext_en, ext_addr[32], addr[32], exp_halt, exp_exc}
  localparam logic [ROW_W-1:0] TBL [NROWS] = '{
    {32'h01, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0000_0000, 1'b1, 1'b0}, // R4
    {32'h02, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0000_0004, 1'b1, 1'b0}, // R4
    {32'h04, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0000_0008, 1'b1, 1'b0}, // R4
    {32'h08, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0000_000C, 1'b1, 1'b0}, // R4
    {32'h10, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0000_0010, 1'b1, 1'b0}, // R4
    {32'h40, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0000_0018, 1'b1, 1'b0}, // R4
    {32'h80, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0000_001C, 1'b1, 1'b0}, // R4
    {32'h20, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0000_0014, 1'b0, 1'b0}, // R3
    {32'hFF, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0000_0014, 1'b0, 1'b0}, // R3
    {32'h01, 2'd0, 1'b1, 1'b0, 32'h0, 32'hFFFF_0000, 1'b1, 1'b0}, // R5
    {32'h80, 2'd0, 1'b1, 1'b0, 32'h0, 32'hFFFF_001C, 1'b1, 1'b0}, // R5
    {32'h01, 2'd0, 1'b1, 1'b0, 32'h0, 32'h0000_0000, 1'b0, 1'b0}, // R5
    {32'h40, 2'd0, 1'b0, 1'b1, 32'h1234, 32'h0000_0018, 1'b0, 1'b0}, // R6
    {32'h40, 2'd0, 1'b0, 1'b1, 32'h1234, 32'h0000_1234, 1'b1, 1'b0}, // R6
    {32'h40, 2'd0, 1'b1, 1'b1, 32'h1234, 32'h0000_1234, 1'b1, 1'b0}, // R6
    {32'h40, 2'd0, 1'b1, 1'b1, 32'h1234, 32'hFFFF_0018, 1'b0, 1'b0}, // R6
    {32'h10, 2'd1, 1'b0, 1'b0, 32'h0, 32'h0000_0010, 1'b0, 1'b1}, // R9
    {32'hFF, 2'd2, 1'b0, 1'b0, 32'h0, 32'h0000_0000, 1'b0, 1'b0}, // R8
    {32'hFF, 2'd3, 1'b0, 1'b0, 32'h0, 32'h0000_001C, 1'b0, 1'b0}, // R8
    {32'h00, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0000_0000, 1'b0, 1'b0}, // R7
    {32'hFD, 2'd0, 1'b0, 1'b0, 32'h0, 32'h0000_0004, 1'b0, 1'b0}, // R7
    {32'h04, 2'd0, 1'b0, 1'b0, 32'h0, 32'h8000_0008, 1'b0, 1'b0}  // R7
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [7:0]  reg_addr = OFS;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        high_vec_sel = 1'b0;
  logic        ext_irq_en = 1'b0;
  logic [31:0] ext_irq_addr = '0;
  logic [1:0]  dbg_mode = 2'd0;
  logic        commit_valid = 1'b0;
  logic [31:0] commit_addr = '0;
  logic        halt_req, dbg_exc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dbg_vcatch_unit i_dbg_vcatch_unit (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .high_vec_sel(high_vec_sel),
    .ext_irq_en(ext_irq_en), .ext_irq_addr(ext_irq_addr), .dbg_mode(dbg_mode),
    .commit_valid(commit_valid), .commit_addr(commit_addr),
    .halt_req(halt_req), .dbg_exc(dbg_exc)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic write_reg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = OFS;
  endtask

  task automatic read_reg(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk); #1;
    d = reg_rdata;
    reg_addr = OFS;
  endtask

  // Drive one commit; sample the event one edge later, then confirm it dropped.
  task automatic commit(logic v, logic [31:0] a, output logic [1:0] ev, output logic [1:0] after);
    @(negedge clk);
    commit_valid = v; commit_addr = a;
    @(posedge clk); #1;
    ev = {halt_req, dbg_exc};
    @(negedge clk);
    commit_valid = 1'b0;
    @(posedge clk); #1;
    after = {halt_req, dbg_exc};
  endtask

  initial begin
    logic [31:0] rd;
    logic [1:0]  ev, after;

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    check("R1 reset halt/exc", {30'b0, halt_req, dbg_exc}, 32'h0);
    read_reg(OFS, rd);
    check("R1 reset read", rd, 32'h0);

    // Table walk
    for (int i = 0; i < NROWS; i++) begin
      logic [ROW_W-1:0] r;
      r = TBL[i];
      write_reg(OFS, r[101:70]);
      @(negedge clk);
      dbg_mode = r[69:68]; high_vec_sel = r[67]; ext_irq_en = r[66];
      ext_irq_addr = r[65:34];
      commit(1'b1, r[33:2], ev, after);
      check($sformatf("R4-table row %0d event (R7 R9 R10)", i), {30'b0, ev}, {30'b0, r[1:0]});
      check($sformatf("R10 row %0d pulse drop", i), {30'b0, after}, 32'h0);
    end
    @(negedge clk);
    dbg_mode = 2'd0; high_vec_sel = 1'b0; ext_irq_en = 1'b0;

    // R3: reserved bits
    write_reg(OFS, 32'hFFFF_FFFF);
    read_reg(OFS, rd);
    check("R3 reserved read zero", rd, 32'h0000_00DF);

    // R2: write/read, other address
    write_reg(OFS, 32'h0000_0093);
    read_reg(OFS, rd);
    check("R2 readback", rd, 32'h0000_0093);
    write_reg(8'h20, 32'h0000_00FF);
    read_reg(OFS, rd);
    check("R2 other addr write ignored", rd, 32'h0000_0093);
    read_reg(8'h20, rd);
    check("R2 other addr read zero", rd, 32'h0);

    // R7: matching address without commit_valid
    commit(1'b0, 32'h0000_0000, ev, after);
    check("R7 no commit_valid", {30'b0, ev}, 32'h0);

    // R10: back-to-back matching commits
    @(negedge clk);
    commit_valid = 1'b1; commit_addr = 32'h0;
    @(posedge clk); #1;
    check("R10 first pulse", {31'b0, halt_req}, 32'h1);
    @(negedge clk); commit_addr = 32'h1C;
    @(posedge clk); #1;
    check("R10 second pulse", {31'b0, halt_req}, 32'h1);
    @(negedge clk); commit_valid = 1'b0;
    @(posedge clk); #1;
    check("R10 clears", {31'b0, halt_req}, 32'h0);

    // R1: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    read_reg(OFS, rd);
    check("R1 mid-run reset clears", rd, 32'h0);
    commit(1'b1, 32'h0000_0000, ev, after);
    check("R1 no catch after reset", {30'b0, ev}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule